// File: doc/BRIEF.md
# GPIO Register Block

This block is a 32-pin general-purpose I/O controller reached through a simple memory-mapped register bus. Software programs each pin's direction and the output levels, and it enables interrupts for individual pins. The pad outputs and their output enables are driven straight from the stored registers.

Output levels are not written directly. Software raises bits through a set address and lowers them through a clear address. A set or clear write is accepted only if its mask overlaps at least one pin configured as an output. When the write is accepted, every bit in the mask is applied, including bits for pins that are inputs. When it is refused, a one-cycle reject pulse is raised.

Incoming pad levels pass through a two-flop synchroniser. They are then combined with the interrupt-enable register to drive eight dedicated interrupt lines for pins 0 to 7 and one shared line for pins 8 to 31.

Top module: `gpio_regblock`

## Requirements
- R1: While reset is held and in the first cycle after it, the level, direction and interrupt-enable registers read as zero, pad_oe, pad_out and all interrupt lines are zero, and bus_ready and wr_reject are low.
- R2: A full-word write to byte offset 0x04 loads the direction register, and a read of 0x04 returns it. pad_oe always equals the direction register. pad_out equals the level register masked by the direction register.
- R3: A full-word write of value V to offset 0x08 with (direction & V) non-zero sets level to level | V. This includes the bits of V that belong to input pins.
- R4: A full-word write of value V to offset 0x0C with (direction & V) non-zero sets level to level & ~V. This includes the bits of V that belong to input pins.
- R5: A set or clear write whose mask has no bit in common with the direction register leaves the level unchanged and drives wr_reject high for exactly one cycle, the cycle in which bus_ready is high for that write.
- R6: Writes to offsets 0x10, 0x14 and 0x18, and to any offset outside the register map, change no register and raise no reject.
- R7: Offset 0x00 is read-only, so a write there has no effect. A read returns level at 0x00, direction at 0x04 and interrupt enable at 0x20. A read of any other offset returns zero.
- R8: An access whose bus_be is not 4'b1111 changes no register, raises no reject and returns zero read data. It is still acknowledged.
- R9: bus_ready is high in the cycle after each cycle with bus_rd or bus_wr high, and low otherwise. bus_rdata is valid in that same cycle.
- R10: An interrupt-enable register is written at offset 0x20. irq_pin[n] for n = 0..7 is high when enable bit n is set and the synchronised pad_in[n] is high. A change on pad_in reaches the interrupt lines after two rising clock edges.
- R11: irq_upper is the OR, over pins 8 to 31, of enable bit AND synchronised pad_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_addr | input | 8 | Byte address of the register |
| bus_be | input | 4 | Byte enables; only all-ones is honoured |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access acknowledge, one cycle after the request |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Per-pin output enable |
| irq_pin | output | 8 | Per-pin interrupt lines, pins 0 to 7 |
| irq_upper | output | 1 | Shared interrupt line, pins 8 to 31 |
| wr_reject | output | 1 | One-cycle pulse per refused set or clear write |

## Verification
The bench builds the block with its default parameters: 32 pins, an 8-bit address and eight dedicated interrupt lines. With those values, every offset in the map is reachable, including the reserved slots at 0x10 to 0x18 and an unmapped slot at 0x24. The shared interrupt line covers a 24-pin upper group, so a bench stimulus on pin 8 and on pin 31 shows both the enabled and the masked path. The 4-bit byte-enable lets partial writes and partial reads be shown to be dropped, and the direction mask 0xF0 leaves both output and input pins in one set or clear mask, so the whole-mask application can be seen.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned OFF_LEVEL  = 'h00;
    localparam int unsigned OFF_DIR    = 'h04;
    localparam int unsigned OFF_SET    = 'h08;
    localparam int unsigned OFF_CLR    = 'h0C;
    localparam int unsigned OFF_QUIET0 = 'h10;
    localparam int unsigned OFF_QUIET1 = 'h14;
    localparam int unsigned OFF_QUIET2 = 'h18;
    localparam int unsigned OFF_IRQEN  = 'h20;

    typedef enum logic [2:0] {
        SEL_LEVEL,
        SEL_DIR,
        SEL_SET,
        SEL_CLR,
        SEL_QUIET,
        SEL_IRQEN,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     req;
        logic     wr_ok;
        logic     rd_ok;
        reg_sel_e sel;
    } bus_cmd_t;

    function automatic logic is_level_op(input reg_sel_e s);
        return (s == SEL_SET) || (s == SEL_CLR);
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BE_W   = 4
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    output bus_cmd_t          cmd_o
);

    logic     full_word;
    reg_sel_e sel;

    assign full_word = &bus_be;

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFF_LEVEL):  sel = SEL_LEVEL;
            ADDR_W'(OFF_DIR):    sel = SEL_DIR;
            ADDR_W'(OFF_SET):    sel = SEL_SET;
            ADDR_W'(OFF_CLR):    sel = SEL_CLR;
            ADDR_W'(OFF_QUIET0),
            ADDR_W'(OFF_QUIET1),
            ADDR_W'(OFF_QUIET2): sel = SEL_QUIET;
            ADDR_W'(OFF_IRQEN):  sel = SEL_IRQEN;
            default:             sel = SEL_NONE;
        endcase
    end

    always_comb begin
        cmd_o.req   = bus_rd | bus_wr;
        cmd_o.wr_ok = bus_wr & full_word;
        cmd_o.rd_ok = bus_rd & ~bus_wr & full_word;
        cmd_o.sel   = sel;
    end

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] level_o,
    output logic [DATA_W-1:0] dir_o,
    output logic [DATA_W-1:0] irqen_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ready_o,
    output logic              reject_o
);

    logic [DATA_W-1:0] level_q, dir_q, irqen_q;
    logic [DATA_W-1:0] level_d, rd_mux;
    logic              hits_output, apply_level, reject_d;

    assign hits_output = |(dir_q & wdata_i);
    assign apply_level = cmd_i.wr_ok && is_level_op(cmd_i.sel) && hits_output;
    assign reject_d    = cmd_i.wr_ok && is_level_op(cmd_i.sel) && !hits_output;

    always_comb begin
        if (cmd_i.sel == SEL_SET) level_d = level_q | wdata_i;
        else                      level_d = level_q & ~wdata_i;
    end

    always_comb begin
        rd_mux = '0;
        if (cmd_i.rd_ok) begin
            case (cmd_i.sel)
                SEL_LEVEL: rd_mux = level_q;
                SEL_DIR:   rd_mux = dir_q;
                SEL_IRQEN: rd_mux = irqen_q;
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            dir_q    <= '0;
            irqen_q  <= '0;
            rdata_o  <= '0;
            ready_o  <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            ready_o  <= cmd_i.req;
            reject_o <= reject_d;
            rdata_o  <= rd_mux;
            if (apply_level) level_q <= level_d;
            if (cmd_i.wr_ok && cmd_i.sel == SEL_DIR)   dir_q   <= wdata_i;
            if (cmd_i.wr_ok && cmd_i.sel == SEL_IRQEN) irqen_q <= wdata_i;
        end
    end

    assign level_o = level_q;
    assign dir_o   = dir_q;
    assign irqen_o = irqen_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int DATA_W = 32,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] async_i,
    output logic [DATA_W-1:0] sync_o
);

    logic [DATA_W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
    parameter int DATA_W  = 32,
    parameter int NUM_LOW = 8
) (
    input  logic [DATA_W-1:0]  en_i,
    input  logic [DATA_W-1:0]  lvl_i,
    output logic [NUM_LOW-1:0] irq_low_o,
    output logic               irq_high_o
);

    localparam int HIGH_W = DATA_W - NUM_LOW;

    logic [DATA_W-1:0] active;

    assign active = en_i & lvl_i;

    for (genvar n = 0; n < NUM_LOW; n++) begin : g_low
        assign irq_low_o[n] = active[n];
    end

    if (HIGH_W > 0) begin : g_high
        assign irq_high_o = |active[DATA_W-1:NUM_LOW];
    end else begin : g_no_high
        assign irq_high_o = 1'b0;
    end

endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
    import gpio_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int NUM_LOW_IRQ = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W/8-1:0]    bus_be,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_ready,
    input  logic [DATA_W-1:0]      pad_in,
    output logic [DATA_W-1:0]      pad_out,
    output logic [DATA_W-1:0]      pad_oe,
    output logic [NUM_LOW_IRQ-1:0] irq_pin,
    output logic                   irq_upper,
    output logic                   wr_reject
);

    localparam int BE_W = DATA_W / 8;

    bus_cmd_t          cmd;
    logic [DATA_W-1:0] level, dir, irqen, pad_sync;

    gpio_bus_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .cmd_o    (cmd)
    );

    gpio_reg_file #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .wdata_i  (bus_wdata),
        .level_o  (level),
        .dir_o    (dir),
        .irqen_o  (irqen),
        .rdata_o  (bus_rdata),
        .ready_o  (bus_ready),
        .reject_o (wr_reject)
    );

    gpio_in_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pad_in),
        .sync_o  (pad_sync)
    );

    gpio_irq_map #(.DATA_W(DATA_W), .NUM_LOW(NUM_LOW_IRQ)) u_irq (
        .en_i       (irqen),
        .lvl_i      (pad_sync),
        .irq_low_o  (irq_pin),
        .irq_high_o (irq_upper)
    );

    assign pad_oe  = dir;
    assign pad_out = level & dir;

endmodule

// File: rtl/gpio_regblock_chk.sv
module gpio_regblock_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W/8-1:0] bus_be,
    input logic                bus_ready,
    input logic                wr_reject,
    input logic [DATA_W-1:0]   pad_out,
    input logic [DATA_W-1:0]   pad_oe
);

    AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |=> bus_ready); // R9

    AST_NO_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !bus_ready); // R9

    AST_REJECT_ONLY_LEVEL_OP: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> ($past(bus_wr) &&
                       ($past(bus_addr) == ADDR_W'('h08) || $past(bus_addr) == ADDR_W'('h0C)))); // R5

    AST_REJECT_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> $stable(pad_out)); // R5

    AST_REJECT_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> bus_ready); // R5

    AST_OE_HOLDS_WITHOUT_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == ADDR_W'('h04)) |=> $stable(pad_oe)); // R2

    AST_PARTIAL_BE_NO_REJECT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !(&bus_be)) |=> !wr_reject); // R8

endmodule

bind gpio_regblock gpio_regblock_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_ready (bus_ready),
    .wr_reject (wr_reject),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/test_gpio_regblock.sv
module test_gpio_regblock;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0, pad_in = '0;
    logic [31:0] bus_rdata, pad_out, pad_oe;
    logic        bus_ready, irq_upper, wr_reject;
    logic [7:0]  irq_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_regblock i_gpio_regblock (
        .clk, .rst, .bus_rd, .bus_wr, .bus_addr, .bus_be, .bus_wdata,
        .bus_rdata, .bus_ready, .pad_in, .pad_out, .pad_oe,
        .irq_pin, .irq_upper, .wr_reject
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic        exp_rej;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h04, 4'hF, 32'h0000_00F0, 32'h0, 1'b0, 4'd2},   // R2 direction
        '{1'b0, 8'h04, 4'hF, 32'h0,         32'h0000_00F0, 1'b0, 4'd2},
        '{1'b1, 8'h08, 4'hF, 32'h0000_0003, 32'h0, 1'b1, 4'd5},   // R5 set, no overlap
        '{1'b0, 8'h00, 4'hF, 32'h0,         32'h0, 1'b0, 4'd5},
        '{1'b1, 8'h08, 4'hF, 32'h0000_0131, 32'h0, 1'b0, 4'd3},   // R3 whole mask
        '{1'b0, 8'h00, 4'hF, 32'h0,         32'h0000_0131, 1'b0, 4'd3},
        '{1'b1, 8'h0C, 4'hF, 32'h0000_0001, 32'h0, 1'b1, 4'd5},   // R5 clear, no overlap
        '{1'b1, 8'h0C, 4'hF, 32'h0000_0021, 32'h0, 1'b0, 4'd4},   // R4 whole mask
        '{1'b0, 8'h00, 4'hF, 32'h0,         32'h0000_0110, 1'b0, 4'd4},
        '{1'b1, 8'h10, 4'hF, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd6},   // R6 quiet slots
        '{1'b1, 8'h14, 4'hF, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd6},
        '{1'b1, 8'h18, 4'hF, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd6},
        '{1'b1, 8'h24, 4'hF, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd6},
        '{1'b1, 8'h00, 4'hF, 32'h0000_FFFF, 32'h0, 1'b0, 4'd7},   // R7 read-only
        '{1'b0, 8'h00, 4'hF, 32'h0,         32'h0000_0110, 1'b0, 4'd7},
        '{1'b0, 8'h08, 4'hF, 32'h0,         32'h0, 1'b0, 4'd7},
        '{1'b0, 8'h3C, 4'hF, 32'h0,         32'h0, 1'b0, 4'd7},
        '{1'b1, 8'h04, 4'h7, 32'h0,         32'h0, 1'b0, 4'd8},   // R8 partial BE
        '{1'b1, 8'h08, 4'hE, 32'h0000_00F0, 32'h0, 1'b0, 4'd8},
        '{1'b0, 8'h04, 4'h3, 32'h0,         32'h0, 1'b0, 4'd8},
        '{1'b1, 8'h20, 4'hF, 32'h0000_0103, 32'h0, 1'b0, 4'd10},  // R10 enable
        '{1'b0, 8'h20, 4'hF, 32'h0,         32'h0000_0103, 1'b0, 4'd10}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic txn(input logic wr, input logic [7:0] addr, input logic [3:0] be,
                       input logic [31:0] data, output logic [31:0] rd,
                       output logic rdy, output logic rej);
        @(negedge clk);
        bus_wr = wr; bus_rd = !wr; bus_addr = addr; bus_be = be; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        rd = bus_rdata; rdy = bus_ready; rej = wr_reject;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        rdy, rej;
        string       tag;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "pad_oe in reset", pad_oe, 32'h0);
        check("R1", "ready in reset", {31'h0, bus_ready}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pad_out after reset", pad_out, 32'h0);
        check("R1", "irq after reset", {23'h0, irq_upper, irq_pin}, 32'h0);
        check("R1", "reject after reset", {31'h0, wr_reject}, 32'h0);
        check("R9", "ready idle", {31'h0, bus_ready}, 32'h0);

        // table walk
        foreach (VECS[i]) begin
            txn(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].data, rd, rdy, rej);
            tag = $sformatf("R%0d", VECS[i].req);
            check(tag, $sformatf("vec %0d rdata", i), rd, VECS[i].exp_rd);
            check(tag, $sformatf("vec %0d reject", i), {31'h0, rej}, {31'h0, VECS[i].exp_rej});
            check("R9", $sformatf("vec %0d ready", i), {31'h0, rdy}, 32'h1);
        end

        // R5 pulse lasts one cycle
        txn(1'b1, 8'h08, 4'hF, 32'h0000_0100, rd, rdy, rej);
        check("R5", "reject on refused set", {31'h0, rej}, 32'h1);
        @(negedge clk);
        check("R5", "reject drops after one cycle", {31'h0, wr_reject}, 32'h0);
        check("R9", "ready drops when idle", {31'h0, bus_ready}, 32'h0);

        // R2 pad outputs
        check("R2", "pad_oe equals direction", pad_oe, 32'h0000_00F0);
        check("R2", "pad_out masked level", pad_out, 32'h0000_0010);

        // R10 / R11 interrupts, enable = 0x103
        pad_in = 32'h0000_0101;
        @(negedge clk);
        check("R10", "irq before second edge", {23'h0, irq_upper, irq_pin}, 32'h0);
        @(negedge clk);
        check("R10", "irq_pin after sync", {24'h0, irq_pin}, 32'h01);
        check("R11", "irq_upper pin 8", {31'h0, irq_upper}, 32'h1);
        pad_in = 32'h8000_0002;
        repeat (2) @(negedge clk);
        check("R10", "irq_pin pin 1", {24'h0, irq_pin}, 32'h02);
        check("R11", "irq_upper masked pin 31", {31'h0, irq_upper}, 32'h0);
        pad_in = 32'h0000_0004;
        repeat (2) @(negedge clk);
        check("R10", "irq_pin masked pin 2", {24'h0, irq_pin}, 32'h00);

        // R1 reset clears programmed state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "pad_oe cleared", pad_oe, 32'h0);
        txn(1'b0, 8'h20, 4'hF, 32'h0, rd, rdy, rej);
        check("R1", "irq enable cleared", rd, 32'h0);
        txn(1'b0, 8'h00, 4'hF, 32'h0, rd, rdy, rej);
        check("R1", "level cleared", rd, 32'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule